// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the effective memory address for a single-register load or store, together with the value a base register would take if the access updates it. It takes a base value and an offset. The offset is either a 12-bit unsigned immediate or an index register. The index is passed through a barrel shifter that shifts left, shifts right with zero fill, or shifts right with sign fill, by 0 to 31 positions. A direction bit selects whether the offset is added to or subtracted from the base.

Two control bits pick the indexing form. In the pre-indexed form, the computed sum addresses memory, and a writeback bit decides whether the sum also goes back into the base register. With writeback off, this is plain offset addressing. In the post-indexed form, the untouched base addresses memory and the sum is always written back. The register file, the memory access and data alignment are handled elsewhere. The datapath is combinational and can be followed by an optional output register.

Top module: `lsu_agu`

## Requirements
- R1: With `use_reg_i`=0, the offset is `imm_i` zero-extended to the data width. `add_i`=1 adds it to `base_i` and `add_i`=0 subtracts it.
- R2: With `use_reg_i`=1, the offset is `index_i` after the shift selected by `shift_type_i` and `shamt_i`. It is then added or subtracted as in R1.
- R3: `shift_type_i` encoding: 2'b00 shifts left with zero fill, 2'b01 shifts right with zero fill, 2'b10 shifts right and fills with bit 31 of the index, and 2'b11 behaves as 2'b00.
- R4: With `pre_i`=1, `addr_o` equals the base/offset sum and `wb_data_o` equals that same sum. `wb_en_o` follows `wb_i`, so `wb_i`=0 gives offset addressing with no base update.
- R5: With `pre_i`=0, `addr_o` equals `base_i` and `wb_data_o` equals the base/offset sum. `wb_en_o` is 1 whatever the value of `wb_i`.
- R6: A shift amount of 0 leaves the index unchanged for every shift type, and an immediate of 0 makes the sum equal to `base_i`.
- R7: Addition and subtraction wrap modulo 2^32, with no saturation and no flag.
- R8: With `REG_OUT`=1 (the default), the outputs show the result one clock after the inputs are presented. While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Unsigned immediate offset |
| index_i | input | 32 | Index register value |
| use_reg_i | input | 1 | 1 selects the shifted index, 0 selects the immediate |
| shift_type_i | input | 2 | Index shift kind (see R3) |
| shamt_i | input | 5 | Index shift amount |
| add_i | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_i | input | 1 | 1 selects pre-indexed, 0 selects post-indexed |
| wb_i | input | 1 | Writeback request for the pre-indexed form |
| addr_o | output | 32 | Effective access address |
| wb_en_o | output | 1 | Base register writeback enable |
| wb_data_o | output | 32 | Base register writeback value |

## Verification
The bench aims at corner cases that a plausible slip would break:
- A right arithmetic shift of a negative index, by a small amount and by 31. A design that zero-fills returns a large positive offset instead of a sign-extended one.
- A right shift by 0. A design that reads the amount 0 as 32 returns zero or all ones instead of the raw index.
- Post-indexed accesses with the writeback bit clear. A design that gates writeback on `wb_i` in this form would fail to update the base. A design that swaps the two values would put the sum on the address port.
- Sums that wrap past zero and past 2^32. These expose a truncated or saturating adder.
- The reserved shift code, which must behave as a left shift.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    SH_LSL  = 2'b00,
    SH_LSR  = 2'b01,
    SH_ASR  = 2'b10,
    SH_RSVD = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/agu_shifter.sv
module agu_shifter
  import agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  val_i,
  input  shift_kind_e        kind_i,
  input  logic [SHAMT_W-1:0] amt_i,
  output logic [DATA_W-1:0]  res_o
);
  logic              go_right;
  logic              fill;
  logic [DATA_W-1:0] stage [SHAMT_W+1];

  assign go_right = (kind_i == SH_LSR) || (kind_i == SH_ASR);
  assign fill     = (kind_i == SH_ASR) ? val_i[DATA_W-1] : 1'b0;
  assign stage[0] = val_i;

  // log-depth shifter: stage k moves by 2^k when amt bit k is set
  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int Dist = 1 << k;
    logic [DATA_W-1:0] moved;
    if (Dist < DATA_W) begin : g_part
      always_comb begin
        if (go_right) moved = {{Dist{fill}}, stage[k][DATA_W-1:Dist]};
        else          moved = {stage[k][DATA_W-1-Dist:0], {Dist{1'b0}}};
      end
    end else begin : g_full
      always_comb begin
        if (go_right) moved = {DATA_W{fill}};
        else          moved = '0;
      end
    end
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  assign res_o = stage[SHAMT_W];
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              add_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] cin;

  // subtract as a + ~b + 1; result wraps at the data width
  assign b_eff = add_i ? b_i : ~b_i;
  assign cin   = {{(DATA_W-1){1'b0}}, ~add_i};
  assign sum_o = a_i + b_eff + cin;
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] addr_d,
  input  logic              wb_en_d,
  input  logic [DATA_W-1:0] wb_data_d,
  output logic [DATA_W-1:0] addr_q,
  output logic              wb_en_q,
  output logic [DATA_W-1:0] wb_data_q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q    <= '0;
        wb_en_q   <= 1'b0;
        wb_data_q <= '0;
      end else begin
        addr_q    <= addr_d;
        wb_en_q   <= wb_en_d;
        wb_data_q <= wb_data_d;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i;
    assign addr_q    = rst_ni ? addr_d    : '0;
    assign wb_en_q   = rst_ni ? wb_en_d   : 1'b0;
    assign wb_data_q = rst_ni ? wb_data_d : '0;
  end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
  import agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SHAMT_W = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  base_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [DATA_W-1:0]  index_i,
  input  logic               use_reg_i,
  input  logic [1:0]         shift_type_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               add_i,
  input  logic               pre_i,
  input  logic               wb_i,
  output logic [DATA_W-1:0]  addr_o,
  output logic               wb_en_o,
  output logic [DATA_W-1:0]  wb_data_o
);
  localparam int PadW = DATA_W - IMM_W;

  shift_kind_e       kind;
  logic [DATA_W-1:0] idx_sh;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] addr_d;
  logic              wb_en_d;

  assign kind    = shift_kind_e'(shift_type_i);
  assign imm_ext = {{PadW{1'b0}}, imm_i};

  agu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .val_i  (index_i),
    .kind_i (kind),
    .amt_i  (shamt_i),
    .res_o  (idx_sh)
  );

  assign offset = use_reg_i ? idx_sh : imm_ext;

  agu_addsub #(.DATA_W(DATA_W)) u_add (
    .a_i   (base_i),
    .b_i   (offset),
    .add_i (add_i),
    .sum_o (sum)
  );

  // pre: sum addresses memory; post: raw base addresses, sum always written back
  always_comb begin
    if (pre_i) begin
      addr_d  = sum;
      wb_en_d = wb_i;
    end else begin
      addr_d  = base_i;
      wb_en_d = 1'b1;
    end
  end

  agu_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_d    (addr_d),
    .wb_en_d   (wb_en_d),
    .wb_data_d (sum),
    .addr_q    (addr_o),
    .wb_en_q   (wb_en_o),
    .wb_data_q (wb_data_o)
  );
endmodule

// File: rtl/lsu_agu_chk.sv
module lsu_agu_chk #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SHAMT_W = 5,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DATA_W-1:0]  base_i,
  input logic [IMM_W-1:0]   imm_i,
  input logic [DATA_W-1:0]  index_i,
  input logic               use_reg_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic               add_i,
  input logic               pre_i,
  input logic               wb_i,
  input logic [DATA_W-1:0]  addr_o,
  input logic               wb_en_o,
  input logic [DATA_W-1:0]  wb_data_o
);
  logic               c_vld;
  logic [DATA_W-1:0]  c_base;
  logic [IMM_W-1:0]   c_imm;
  logic [DATA_W-1:0]  c_index;
  logic               c_use_reg;
  logic [SHAMT_W-1:0] c_shamt;
  logic               c_add;
  logic               c_pre;
  logic               c_wb;

  // align inputs with the cycle their result appears at the outputs
  if (REG_OUT) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c_vld <= 1'b0; c_base <= '0; c_imm <= '0; c_index <= '0;
        c_use_reg <= 1'b0; c_shamt <= '0; c_add <= 1'b0; c_pre <= 1'b0; c_wb <= 1'b0;
      end else begin
        c_vld <= 1'b1; c_base <= base_i; c_imm <= imm_i; c_index <= index_i;
        c_use_reg <= use_reg_i; c_shamt <= shamt_i; c_add <= add_i; c_pre <= pre_i; c_wb <= wb_i;
      end
    end
  end else begin : g_pass
    assign c_vld = 1'b1; assign c_base = base_i; assign c_imm = imm_i;
    assign c_index = index_i; assign c_use_reg = use_reg_i; assign c_shamt = shamt_i;
    assign c_add = add_i; assign c_pre = pre_i; assign c_wb = wb_i;
  end

  logic [DATA_W-1:0] c_imm_ext;
  assign c_imm_ext = {{(DATA_W-IMM_W){1'b0}}, c_imm};

  assert_post_form_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_vld && !c_pre) |-> (addr_o == c_base && wb_en_o));

  assert_pre_form_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_vld && c_pre) |-> (addr_o == wb_data_o && wb_en_o == c_wb));

  assert_imm_offset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_vld && !c_use_reg) |->
      (wb_data_o == (c_add ? c_base + c_imm_ext : c_base - c_imm_ext)));

  assert_zero_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_vld && c_use_reg && c_shamt == '0) |->
      (wb_data_o == (c_add ? c_base + c_index : c_base - c_index)));
endmodule

bind lsu_agu lsu_agu_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .base_i(base_i), .imm_i(imm_i), .index_i(index_i),
  .use_reg_i(use_reg_i), .shamt_i(shamt_i), .add_i(add_i), .pre_i(pre_i), .wb_i(wb_i),
  .addr_o(addr_o), .wb_en_o(wb_en_o), .wb_data_o(wb_data_o)
);

// File: tb/lsu_agu_test.sv
module lsu_agu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] base_i = '0;
  logic [11:0] imm_i = '0;
  logic [31:0] index_i = '0;
  logic        use_reg_i = 1'b0;
  logic [1:0]  shift_type_i = '0;
  logic [4:0]  shamt_i = '0;
  logic        add_i = 1'b0;
  logic        pre_i = 1'b0;
  logic        wb_i = 1'b0;
  logic [31:0] addr_o;
  logic        wb_en_o;
  logic [31:0] wb_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] addr;
    logic        wb_en;
    logic [31:0] wb_data;
  } exp_t;
  exp_t sb[$];

  always #10 clk_i = ~clk_i;

  lsu_agu #(.REG_OUT(1'b1)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_i(base_i), .imm_i(imm_i), .index_i(index_i),
    .use_reg_i(use_reg_i), .shift_type_i(shift_type_i), .shamt_i(shamt_i), .add_i(add_i),
    .pre_i(pre_i), .wb_i(wb_i), .addr_o(addr_o), .wb_en_o(wb_en_o), .wb_data_o(wb_data_o)
  );

  task automatic drive(input string tag, input logic [31:0] b, input logic [11:0] im,
                       input logic [31:0] ix, input logic ur, input logic [1:0] st,
                       input logic [4:0] sh, input logic ad, input logic pr, input logic w);
    logic [31:0] off;
    logic [31:0] sum;
    exp_t e;
    @(negedge clk_i);
    base_i = b; imm_i = im; index_i = ix; use_reg_i = ur; shift_type_i = st;
    shamt_i = sh; add_i = ad; pre_i = pr; wb_i = w;
    if (!ur)             off = {20'd0, im};
    else if (st == 2'b01) off = ix >> sh;
    else if (st == 2'b10) off = $unsigned($signed(ix) >>> sh);
    else                 off = ix << sh;
    sum = ad ? b + off : b - off;
    e.tag = tag;
    e.addr = pr ? sum : b;
    e.wb_en = pr ? w : 1'b1;
    e.wb_data = sum;
    sb.push_back(e);
  endtask

  // monitor: results appear one edge after the driving negedge
  initial begin
    @(posedge rst_ni);
    forever begin
      @(posedge clk_i);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (addr_o !== e.addr || wb_en_o !== e.wb_en || wb_data_o !== e.wb_data) begin
          fails++;
          $display("FAIL %s: got addr=%h wb_en=%b wb_data=%h, exp addr=%h wb_en=%b wb_data=%h",
                   e.tag, addr_o, wb_en_o, wb_data_o, e.addr, e.wb_en, e.wb_data);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got no completion, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    base_i = 32'hDEAD_BEEF; imm_i = 12'hFFF; pre_i = 1'b1; wb_i = 1'b1;
    repeat (3) @(negedge clk_i);
    checks++;
    if (addr_o !== '0 || wb_en_o !== 1'b0 || wb_data_o !== '0) begin
      fails++;
      $display("FAIL R8 reset: got %h/%b/%h exp 0/0/0", addr_o, wb_en_o, wb_data_o);
    end
    rst_ni = 1'b1;
    // R1 immediate add/sub, offset form
    drive("R1 imm add",      32'h0000_1000, 12'd12,  '0, 0, 2'b00, 0, 1, 1, 0);
    drive("R1 imm sub",      32'h0000_1000, 12'd8,   '0, 0, 2'b00, 0, 0, 1, 0);
    drive("R1 imm max",      32'h0000_0010, 12'hFFF, '0, 0, 2'b00, 0, 1, 1, 0);
    // R2/R3 register index with each shift kind
    drive("R2 lsl2",         32'h2000_0000, '0, 32'd5,          1, 2'b00, 2,  1, 1, 0);
    drive("R3 lsr4",         32'h0000_0100, '0, 32'hF000_0F00,  1, 2'b01, 4,  1, 1, 0);
    drive("R3 asr8 neg",     32'h0001_0000, '0, 32'h8000_1200,  1, 2'b10, 8,  1, 1, 0);
    drive("R3 asr31 neg",    32'h0000_0040, '0, 32'hC000_0000,  1, 2'b10, 31, 1, 1, 0);
    drive("R3 asr pos",      32'h0000_0040, '0, 32'h4000_0000,  1, 2'b10, 30, 0, 1, 0);
    drive("R3 rsvd as lsl",  32'h0000_0000, '0, 32'h0000_0003,  1, 2'b11, 3,  1, 1, 0);
    drive("R3 lsl31",        32'h0000_0001, '0, 32'h0000_0003,  1, 2'b00, 31, 1, 1, 0);
    // R6 zero offset / zero shift
    drive("R6 lsr0",         32'h0000_0004, '0, 32'h8000_0001,  1, 2'b01, 0,  1, 1, 0);
    drive("R6 asr0",         32'h0000_0004, '0, 32'h8000_0001,  1, 2'b10, 0,  0, 1, 0);
    drive("R6 imm0",         32'h1234_5678, 12'd0, '0, 0, 2'b00, 0, 1, 1, 1);
    // R4 pre-indexed writeback
    drive("R4 pre wb",       32'h0000_2000, 12'd4,  '0, 0, 2'b00, 0, 1, 1, 1);
    drive("R4 pre reg wb",   32'h0000_2000, '0, 32'd3, 1, 2'b00, 1, 0, 1, 1);
    // R5 post-indexed, writeback bit ignored
    drive("R5 post wb0",     32'h0000_3000, 12'd4,  '0, 0, 2'b00, 0, 1, 0, 0);
    drive("R5 post wb1 sub", 32'h0000_3000, '0, 32'd2, 1, 2'b00, 3, 0, 0, 1);
    // R7 wrap
    drive("R7 wrap add",     32'hFFFF_FFF0, 12'h020, '0, 0, 2'b00, 0, 1, 1, 0);
    drive("R7 wrap sub",     32'h0000_0004, 12'h010, '0, 0, 2'b00, 0, 0, 0, 0);
    // R8 back-to-back vectors: each result appears one clock later
    drive("R8 latency a",    32'h0000_0100, 12'd1, '0, 0, 2'b00, 0, 1, 1, 1);
    drive("R8 latency b",    32'h0000_0200, 12'd2, '0, 0, 2'b00, 0, 0, 0, 1);
    repeat (4) @(negedge clk_i);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R8 drain: got %0d pending, exp 0", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule